// File: doc/BRIEF.md
# Serial Port Register Front-End with One-Character Receive Holder

This block is the software-visible register face of a serial port. It decodes word-addressed accesses from a simple synchronous bus, with a one-cycle write strobe and registered read data. It keeps the control words, a set of stored-only timing and FIFO setup words, and two status words. A single holding register stands in for a receive FIFO. Received bytes and line-break events arrive on a byte-stream input that reports ready only while the holder is empty. Bytes written to the transmit word leave on a byte-stream output when transmit is enabled. A single registered level interrupt is driven from the receive-ready and transmit-ready flags and their enables.

Reading the receive word empties the holder and drops both receive-ready flags. Status writes cannot disturb the fixed flags. Writing the second control word with its active-low soft-reset bit at zero returns the block to its reset state and then stores the written value with that bit set. A boot preset input, sampled while reset is held, starts the block with the port and transmitter already enabled.

Top module: `uart_regfront`

## Requirements
- R1: After reset with boot_preset low: status-1 reads 0x6040 (bit 14 RTS, bit 13 transmit-ready, bit 6 receiver idle), status-2 reads 0x4028 (bit 14 transmit FIFO empty, bit 5 carrier in, bit 3 transmit done), the test word reads 0x0060 (bit 6 transmit empty, bit 5 receive empty), control-1 reads 0, control-2 reads 0x0001, control-3 reads 0x0700, the baud count reads 4, the modulator reads 0, the receive word reads 0x4000 (error bit 14), irq is 0 and rx_ready is 1.
- R2: When boot_preset is high during reset, control-1 comes out as 0x0001 (port enable) and control-2 as 0x0004 (transmit enable), so a transmit write works with no setup.
- R3: Registers sit at word index (byte address shifted right by two): receive 0x00, transmit 0x10, control-1..4 at 0x20..0x23, FIFO setup 0x24, status-1 0x25, status-2 0x26, baud increment 0x29, modulator 0x2A, baud count 0x2B, millisecond 0x2C, test 0x2D. Control-4, baud increment and every unmapped index read 0.
- R4: Control-1, control-2, control-3, FIFO setup, modulator and millisecond keep only the low 16 bits of a write and read them back; a write to the baud increment index lands in the baud count register.
- R5: A byte accepted while rx_ready is 1 is stored, sets status-1 bit 9 and status-2 bit 0, and clears test bit 5; rx_ready stays 0 while the holder is full, and input offered then is dropped.
- R6: A break event is stored as the word 0x0800 with the same flag updates as a byte; a break and a byte offered in the same cycle store the break.
- R7: Reading the receive word while full returns the held word with bit 15 set and empties the holder (status-1 bit 9, status-2 bit 0 cleared, test bit 5 set); reading it while empty returns the held word without bit 15 and changes nothing.
- R8: Writes to status-1, status-2, the test word and control-4 change no readable value.
- R9: A write to the transmit index puts its low byte on tx_data with tx_valid high for one cycle, in the cycle after the write, only when control-2 bit 2 is set; otherwise tx_valid stays low.
- R10: Status-1 bit 13 reads 0 in the cycle right after a transmit and 1 again afterwards.
- R11: irq equals (status-1 bit 9 AND control-1 bit 9) OR (status-1 bit 13 AND control-1 bit 13 AND control-1 bit 6) OR (control-1 bit 6 AND test bit 6), registered one cycle after the flags it reads.
- R12: Writing control-2 with bit 0 at zero restores the R1 state of status, test, control-1, control-3, modulator, baud count and receive holder, keeps FIFO setup and millisecond, and stores the written value with bit 0 set into control-2.
- R13: A receive-word read and an offered byte in the same cycle: with the holder full the read empties it and the byte is dropped; with the holder empty the read returns the old word without bit 15 and the byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boot_preset | input | 1 | Selects the enabled start-up state while reset is held |
| addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | One-cycle write strobe |
| wdata | input | DATA_W | Write data |
| rd_en | input | 1 | One-cycle read strobe |
| rdata | output | DATA_W | Read data, valid the cycle after rd_en |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_brk | input | 1 | Line break offered |
| rx_ready | output | 1 | Holder can take a byte or break |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The receive holder can be emptied by a bus read in the same cycle a new byte is offered on the stream input, and the outcome depends on whether the holder was full. The bench raises rd_en on the receive word and rx_valid in one cycle, once with the holder full and once empty, then judges the returned word, the flags and a follow-up read against R13: a full holder must yield the old byte with the ready bit and drop the new byte, an empty one must keep the new byte.

// File: rtl/ufr_pkg.sv
package ufr_pkg;

   typedef enum logic [3:0] {
      RG_NONE, RG_RXD, RG_TXD, RG_CTL1, RG_CTL2, RG_CTL3, RG_CTL4, RG_FIFO,
      RG_STAT1, RG_STAT2, RG_BINC, RG_BMOD, RG_BCNT, RG_MSEC, RG_TEST
   } reg_id_e;

   // word indices (software-visible map)
   localparam logic [7:0] W_RXD   = 8'h00;
   localparam logic [7:0] W_TXD   = 8'h10;
   localparam logic [7:0] W_CTL1  = 8'h20;
   localparam logic [7:0] W_CTL2  = 8'h21;
   localparam logic [7:0] W_CTL3  = 8'h22;
   localparam logic [7:0] W_CTL4  = 8'h23;
   localparam logic [7:0] W_FIFO  = 8'h24;
   localparam logic [7:0] W_STAT1 = 8'h25;
   localparam logic [7:0] W_STAT2 = 8'h26;
   localparam logic [7:0] W_BINC  = 8'h29;
   localparam logic [7:0] W_BMOD  = 8'h2A;
   localparam logic [7:0] W_BCNT  = 8'h2B;
   localparam logic [7:0] W_MSEC  = 8'h2C;
   localparam logic [7:0] W_TEST  = 8'h2D;

   localparam int REG_W = 16;

   // status-1 bits
   localparam int S1_RXIDLE = 6;
   localparam int S1_RXRDY  = 9;
   localparam int S1_TXRDY  = 13;
   localparam int S1_RTS    = 14;
   // status-2 bits
   localparam int S2_RXDATA = 0;
   localparam int S2_TXDONE = 3;
   localparam int S2_DCD    = 5;
   localparam int S2_TXFE   = 14;
   // test word bits
   localparam int T_RXEMPTY = 5;
   localparam int T_TXEMPTY = 6;
   // control-1 bits (interrupt enables line up with status-1)
   localparam int C1_EN    = 0;
   localparam int C1_TXEIE = 6;
   localparam int C1_RXIE  = S1_RXRDY;
   localparam int C1_TXIE  = S1_TXRDY;
   // control-2 bits
   localparam int C2_NSRST = 0;
   localparam int C2_TXEN  = 2;
   // receive word bits
   localparam int RD_CHRDY = 15;

   localparam logic [REG_W-1:0] RXHOLD_RST = 16'h4000;
   localparam logic [REG_W-1:0] BREAK_WORD = 16'h0800;

   // stored-only setup bank: slot 0 ctl3, 1 fifo, 2 baud count, 3 modulator, 4 millisecond
   localparam int NCFG   = 5;
   localparam int CF_CTL3 = 0;
   localparam int CF_FIFO = 1;
   localparam int CF_BCNT = 2;
   localparam int CF_BMOD = 3;
   localparam int CF_MSEC = 4;

   function automatic logic [REG_W-1:0] cfg_init(input int slot);
      case (slot)
         CF_CTL3: cfg_init = 16'h0700;
         CF_BCNT: cfg_init = 16'h0004;
         default: cfg_init = '0;
      endcase
   endfunction

   function automatic bit cfg_soft(input int slot);
      cfg_soft = (slot == CF_CTL3) || (slot == CF_BCNT) || (slot == CF_BMOD);
   endfunction

endpackage

// File: rtl/ufr_decode.sv
module ufr_decode
   import ufr_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_id_e           id
);
   localparam int WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   assign word = addr[ADDR_W-1:2];

   function automatic logic hit(input logic [WORD_W-1:0] w, input logic [7:0] idx);
      hit = (w == WORD_W'(idx));
   endfunction

   always_comb begin
      id = RG_NONE;
      if      (hit(word, W_RXD))   id = RG_RXD;
      else if (hit(word, W_TXD))   id = RG_TXD;
      else if (hit(word, W_CTL1))  id = RG_CTL1;
      else if (hit(word, W_CTL2))  id = RG_CTL2;
      else if (hit(word, W_CTL3))  id = RG_CTL3;
      else if (hit(word, W_CTL4))  id = RG_CTL4;
      else if (hit(word, W_FIFO))  id = RG_FIFO;
      else if (hit(word, W_STAT1)) id = RG_STAT1;
      else if (hit(word, W_STAT2)) id = RG_STAT2;
      else if (hit(word, W_BINC))  id = RG_BINC;
      else if (hit(word, W_BMOD))  id = RG_BMOD;
      else if (hit(word, W_BCNT))  id = RG_BCNT;
      else if (hit(word, W_MSEC))  id = RG_MSEC;
      else if (hit(word, W_TEST))  id = RG_TEST;
   end

   wire unused_lo = ^addr[1:0];
endmodule

// File: rtl/ufr_cfg_bank.sv
module ufr_cfg_bank
   import ufr_pkg::*;
#(
   parameter int N = NCFG
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  soft_rst,
   input  logic [N-1:0]          we,
   input  logic [REG_W-1:0]      wval,
   output logic [N-1:0][REG_W-1:0] q
);
   for (genvar g = 0; g < N; g++) begin : g_slot
      localparam logic [REG_W-1:0] INIT = cfg_init(g);
      if (cfg_soft(g)) begin : g_soft
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q[g] <= INIT;
            else if (soft_rst) q[g] <= INIT;
            else if (we[g])    q[g] <= wval;
         end
      end else begin : g_keep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q[g] <= INIT;
            else if (we[g]) q[g] <= wval;
         end
      end
   end
endmodule

// File: rtl/ufr_rx_hold.sv
module ufr_rx_hold
   import ufr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             take,
   input  logic             rx_valid,
   input  logic [7:0]       rx_data,
   input  logic             rx_brk,
   output logic             full,
   output logic [REG_W-1:0] hold
);
   logic accept;
   assign accept = (rx_valid || rx_brk) && !full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold <= RXHOLD_RST;
         full <= 1'b0;
      end else if (soft_rst) begin
         hold <= RXHOLD_RST;
         full <= 1'b0;
      end else if (accept) begin
         hold <= rx_brk ? BREAK_WORD : {8'h00, rx_data};
         full <= 1'b1;
      end else if (take && full) begin
         full <= 1'b0;
      end
   end
endmodule

// File: rtl/ufr_irq.sv
module ufr_irq
   import ufr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] stat1,
   input  logic [REG_W-1:0] ctl1,
   input  logic             tx_empty,
   output logic             irq
);
   logic rx_term, tx_term, te_term;
   assign rx_term = stat1[S1_RXRDY] && ctl1[C1_RXIE];
   assign tx_term = stat1[S1_TXRDY] && ctl1[C1_TXIE] && ctl1[C1_TXEIE];
   assign te_term = ctl1[C1_TXEIE] && tx_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= rx_term || tx_term || te_term;
   end

   wire unused_bits = ^{stat1[REG_W-1:S1_TXRDY+1], stat1[S1_TXRDY-1:S1_RXRDY+1],
                        stat1[S1_RXRDY-1:0], ctl1[REG_W-1:C1_TXIE+1],
                        ctl1[C1_TXIE-1:C1_RXIE+1], ctl1[C1_RXIE-1:C1_TXEIE+1],
                        ctl1[C1_TXEIE-1:0]};
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
   import ufr_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boot_preset,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rdata,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   input  logic              rx_brk,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              irq
);
   if (ADDR_W < 8) begin : g_chk_addr
      $error("ADDR_W must cover word index 0x2D");
   end
   if (DATA_W < REG_W) begin : g_chk_data
      $error("DATA_W must hold a 16-bit register");
   end

   localparam logic [REG_W-1:0] BOOT_CTL1 = REG_W'(1) << C1_EN;
   localparam logic [REG_W-1:0] BOOT_CTL2 = REG_W'(1) << C2_TXEN;
   localparam logic [REG_W-1:0] RST_CTL2  = REG_W'(1) << C2_NSRST;

   reg_id_e          id;
   logic [REG_W-1:0] wv;
   logic             wr_ctl1, wr_ctl2, soft_rst, tx_fire, rd_take;
   logic [REG_W-1:0] ctl1_q, ctl2_q;
   logic             trdy_low_q;
   logic [NCFG-1:0]  cfg_we;
   logic [NCFG-1:0][REG_W-1:0] cfg_q;
   logic             full_q;
   logic [REG_W-1:0] hold_q;
   logic [REG_W-1:0] stat1, stat2, test_w, rd_val;

   ufr_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(addr), .id(id));

   assign wv       = wdata[REG_W-1:0];
   assign wr_ctl1  = wr_en && (id == RG_CTL1);
   assign wr_ctl2  = wr_en && (id == RG_CTL2);
   assign soft_rst = wr_ctl2 && !wv[C2_NSRST];
   assign tx_fire  = wr_en && (id == RG_TXD) && ctl2_q[C2_TXEN];
   assign rd_take  = rd_en && (id == RG_RXD);

   if (DATA_W > REG_W) begin : g_wide
      wire unused_hi = ^wdata[DATA_W-1:REG_W];
   end

   // control words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl1_q <= boot_preset ? BOOT_CTL1 : '0;
         ctl2_q <= boot_preset ? BOOT_CTL2 : RST_CTL2;
      end else begin
         if (soft_rst)     ctl1_q <= '0;
         else if (wr_ctl1) ctl1_q <= wv;
         if (wr_ctl2)      ctl2_q <= wv | RST_CTL2;
      end
   end

   // transmit path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_valid   <= 1'b0;
         tx_data    <= '0;
         trdy_low_q <= 1'b0;
      end else begin
         tx_valid   <= tx_fire;
         trdy_low_q <= tx_fire;
         if (tx_fire) tx_data <= wv[7:0];
      end
   end

   // stored-only setup bank
   always_comb begin
      cfg_we          = '0;
      cfg_we[CF_CTL3] = wr_en && (id == RG_CTL3);
      cfg_we[CF_FIFO] = wr_en && (id == RG_FIFO);
      cfg_we[CF_BCNT] = wr_en && (id == RG_BINC);
      cfg_we[CF_BMOD] = wr_en && (id == RG_BMOD);
      cfg_we[CF_MSEC] = wr_en && (id == RG_MSEC);
   end

   ufr_cfg_bank #(.N(NCFG)) u_cfg (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .we(cfg_we), .wval(wv), .q(cfg_q)
   );

   ufr_rx_hold u_rx (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .take(rd_take),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_brk(rx_brk),
      .full(full_q), .hold(hold_q)
   );

   assign rx_ready = !full_q;

   // status composition
   always_comb begin
      stat1            = '0;
      stat1[S1_RTS]    = 1'b1;
      stat1[S1_RXIDLE] = 1'b1;
      stat1[S1_TXRDY]  = !trdy_low_q;
      stat1[S1_RXRDY]  = full_q;
      stat2            = '0;
      stat2[S2_TXFE]   = 1'b1;
      stat2[S2_TXDONE] = 1'b1;
      stat2[S2_DCD]    = 1'b1;
      stat2[S2_RXDATA] = full_q;
      test_w            = '0;
      test_w[T_TXEMPTY] = 1'b1;
      test_w[T_RXEMPTY] = !full_q;
   end

   ufr_irq u_irq (
      .clk(clk), .rst_n(rst_n), .stat1(stat1), .ctl1(ctl1_q),
      .tx_empty(test_w[T_TXEMPTY]), .irq(irq)
   );

   // read mux
   always_comb begin
      case (id)
         RG_RXD:   rd_val = hold_q | (REG_W'(full_q) << RD_CHRDY);
         RG_CTL1:  rd_val = ctl1_q;
         RG_CTL2:  rd_val = ctl2_q;
         RG_CTL3:  rd_val = cfg_q[CF_CTL3];
         RG_FIFO:  rd_val = cfg_q[CF_FIFO];
         RG_STAT1: rd_val = stat1;
         RG_STAT2: rd_val = stat2;
         RG_BMOD:  rd_val = cfg_q[CF_BMOD];
         RG_BCNT:  rd_val = cfg_q[CF_BCNT];
         RG_MSEC:  rd_val = cfg_q[CF_MSEC];
         RG_TEST:  rd_val = test_w;
         default:  rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= DATA_W'(rd_val);
   end
endmodule

// File: rtl/ufr_chk.sv
module ufr_chk #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [DATA_W-1:0] wdata,
   input logic              rd_en,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic              tx_valid,
   input logic              irq,
   input logic [15:0]       ctl1,
   input logic [15:0]       ctl2,
   input logic [15:0]       ctl3,
   input logic [15:0]       hold,
   input logic              full
);
   localparam int WORD_W = ADDR_W - 2;
   logic [WORD_W-1:0] word;
   assign word = addr[ADDR_W-1:2];

   // R9
   tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(wr_en && (word == WORD_W'(8'h10)) && ctl2[2]));

   // R5
   rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready && !wr_en) |=> $stable(hold));

   // R12
   soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (word == WORD_W'(8'h21)) && !wdata[0]) |=>
         (ctl2[0] && (ctl3 == 16'h0700) && !full && (ctl1 == 16'h0000)));

   // R7
   rx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (word == '0) && full && !wr_en) |=> !full);

   // R11
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ctl1 & 16'h2240) == 16'h0000) |-> !irq);
endmodule

bind uart_regfront ufr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
   .rd_en(rd_en), .rx_valid(rx_valid), .rx_ready(rx_ready),
   .tx_valid(tx_valid), .irq(irq), .ctl1(ctl1_q), .ctl2(ctl2_q),
   .ctl3(cfg_q[0]), .hold(hold_q), .full(full_q)
);

// File: tb/sim_uart_regfront.sv
module sim_uart_regfront;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 12;
   localparam int DATA_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              boot_preset = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic              wr_en = 1'b0;
   logic [DATA_W-1:0] wdata = '0;
   logic              rd_en = 1'b0;
   logic [DATA_W-1:0] rdata;
   logic              rx_valid = 1'b0;
   logic [7:0]        rx_data = '0;
   logic              rx_brk = 1'b0;
   logic              rx_ready, tx_valid, irq;
   logic [7:0]        tx_data;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   uart_regfront #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
      .clk(clk), .rst_n(rst_n), .boot_preset(boot_preset), .addr(addr),
      .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en), .rdata(rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_brk(rx_brk),
      .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
         $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
      end
   endtask

   // all tasks are entered and left at a falling edge
   task automatic wr(input logic [7:0] w, input logic [31:0] d);
      addr = ADDR_W'(w) << 2; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] w, output logic [31:0] d);
      addr = ADDR_W'(w) << 2; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic rx_put(input logic [7:0] b, input logic brk);
      rx_valid = !brk; rx_brk = brk; rx_data = b;
      @(negedge clk);
      rx_valid = 1'b0; rx_brk = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset(input logic boot);
      rst_n = 1'b0; boot_preset = boot;
      idle(3);
      rst_n = 1'b1;
      idle(1);
   endtask

   initial begin
      logic [31:0] d;
      @(negedge clk);
      do_reset(1'b0);

      // R1 reset state
      rd(8'h25, d); check("R1 status1", d, 32'h6040);
      rd(8'h26, d); check("R1 status2", d, 32'h4028);
      rd(8'h2D, d); check("R1 test", d, 32'h0060);
      rd(8'h20, d); check("R1 ctl1", d, 32'h0);
      rd(8'h21, d); check("R1 ctl2", d, 32'h0001);
      rd(8'h22, d); check("R1 ctl3", d, 32'h0700);
      rd(8'h2B, d); check("R1 baud count", d, 32'h4);
      rd(8'h2A, d); check("R1 modulator", d, 32'h0);
      rd(8'h00, d); check("R1 rx word", d, 32'h4000);
      check("R1 irq", {31'b0, irq}, 32'h0);
      check("R1 rx_ready", {31'b0, rx_ready}, 32'h1);

      // R3 zero reads
      rd(8'h23, d); check("R3 ctl4 reads zero", d, 32'h0);
      rd(8'h29, d); check("R3 increment reads zero", d, 32'h0);
      rd(8'h3F, d); check("R3 unmapped reads zero", d, 32'h0);
      rd(8'h11, d); check("R3 unmapped 0x11", d, 32'h0);

      // R4 low-16 storage
      wr(8'h22, 32'hABCD_1234); rd(8'h22, d); check("R4 ctl3", d, 32'h1234);
      wr(8'h24, 32'hFFFF_0081); rd(8'h24, d); check("R4 fifo", d, 32'h0081);
      wr(8'h2A, 32'h0001_BEEF); rd(8'h2A, d); check("R4 modulator", d, 32'hBEEF);
      wr(8'h2C, 32'h7777_03E8); rd(8'h2C, d); check("R4 millisecond", d, 32'h03E8);
      wr(8'h29, 32'h5555_0055); rd(8'h2B, d); check("R4 increment to count", d, 32'h0055);
      rd(8'h29, d); check("R4 increment still zero", d, 32'h0);

      // R8 ignored writes
      wr(8'h25, 32'hFFFF_FFFF); rd(8'h25, d); check("R8 status1 write", d, 32'h6040);
      wr(8'h2D, 32'h0); rd(8'h2D, d); check("R8 test write", d, 32'h0060);
      wr(8'h23, 32'hFFFF); rd(8'h23, d); check("R8 ctl4 write", d, 32'h0);

      // R5 / R7 sweep over every byte value
      for (int v = 0; v < 256; v++) begin
         rx_put(8'(v), 1'b0);
         check("R5 rx_ready low", {31'b0, rx_ready}, 32'h0);
         rd(8'h00, d); check("R7 full read", d, 32'h8000 | v);
         rd(8'h00, d); check("R7 empty read", d, 32'(v));
      end
      rx_put(8'h3C, 1'b0);
      rd(8'h25, d); check("R5 status1 rx-ready", d, 32'h6240);
      rd(8'h26, d); check("R5 status2 data", d, 32'h4029);
      rd(8'h2D, d); check("R5 test rx-empty clear", d, 32'h0040);
      wr(8'h26, 32'hFFFF); rd(8'h26, d); check("R8 status2 write", d, 32'h4029);
      rx_put(8'h99, 1'b0);
      rd(8'h00, d); check("R5 offered while full dropped", d, 32'h803C);
      rd(8'h25, d); check("R7 status1 after take", d, 32'h6040);
      rd(8'h26, d); check("R7 status2 after take", d, 32'h4028);
      rd(8'h2D, d); check("R7 test after take", d, 32'h0060);

      // R6 break
      rx_put(8'h00, 1'b1);
      rd(8'h00, d); check("R6 break word", d, 32'h8800);
      rx_valid = 1'b1; rx_brk = 1'b1; rx_data = 8'h41;
      @(negedge clk); rx_valid = 1'b0; rx_brk = 1'b0;
      rd(8'h00, d); check("R6 break beats byte", d, 32'h8800);

      // R9 / R10 transmit
      wr(8'h10, 32'h0000_0141);
      check("R9 gated off", {31'b0, tx_valid}, 32'h0);
      wr(8'h21, 32'h0000_0005);
      wr(8'h10, 32'h0000_0141);
      check("R9 tx_valid", {31'b0, tx_valid}, 32'h1);
      check("R9 tx_data", {24'b0, tx_data}, 32'h41);
      rd(8'h25, d); check("R10 ready low", d, 32'h4040);
      check("R9 single pulse", {31'b0, tx_valid}, 32'h0);
      rd(8'h25, d); check("R10 ready back", d, 32'h6040);

      // R11 interrupt sweep: 3 enables x holder full/empty
      for (int f = 0; f < 2; f++) begin
         for (int e = 0; e < 8; e++) begin
            logic [15:0] c1;
            logic exp_irq;
            c1 = 16'((e & 1) ? 16'h0200 : 0) | 16'((e & 2) ? 16'h2000 : 0)
               | 16'((e & 4) ? 16'h0040 : 0);
            exp_irq = ((f == 1) && ((e & 1) != 0)) || ((e & 4) != 0);
            wr(8'h20, {16'h0, c1});
            idle(1);
            check("R11 irq", {31'b0, irq}, {31'b0, exp_irq});
         end
         if (f == 0) begin
            rx_put(8'h12, 1'b0);
         end
      end
      wr(8'h20, 32'h0200); idle(1);
      check("R11 irq rx", {31'b0, irq}, 32'h1);
      rd(8'h00, d); idle(1);
      check("R11 irq drops after take", {31'b0, irq}, 32'h0);

      // R13 same-cycle read and arrival
      rx_put(8'hA1, 1'b0);
      addr = '0; rd_en = 1'b1; rx_valid = 1'b1; rx_data = 8'hB2;
      @(negedge clk); rd_en = 1'b0; rx_valid = 1'b0; d = rdata;
      check("R13 full: read returns old", d, 32'h80A1);
      check("R13 full: holder emptied", {31'b0, rx_ready}, 32'h1);
      rd(8'h00, d); check("R13 full: new byte dropped", d, 32'h00A1);
      addr = '0; rd_en = 1'b1; rx_valid = 1'b1; rx_data = 8'hC3;
      @(negedge clk); rd_en = 1'b0; rx_valid = 1'b0; d = rdata;
      check("R13 empty: read plain", d, 32'h00A1);
      rd(8'h00, d); check("R13 empty: byte stored", d, 32'h80C3);

      // R12 soft reset
      wr(8'h22, 32'h1234);
      wr(8'h2A, 32'h00AA);
      wr(8'h24, 32'h0042);
      wr(8'h20, 32'h2241);
      rx_put(8'h5E, 1'b0);
      wr(8'h21, 32'h0000_0006);
      rd(8'h21, d); check("R12 ctl2 stored with bit0", d, 32'h0007);
      rd(8'h22, d); check("R12 ctl3 restored", d, 32'h0700);
      rd(8'h2A, d); check("R12 modulator restored", d, 32'h0);
      rd(8'h2B, d); check("R12 count restored", d, 32'h4);
      rd(8'h24, d); check("R12 fifo kept", d, 32'h0042);
      rd(8'h2C, d); check("R12 millisecond kept", d, 32'h03E8);
      rd(8'h20, d); check("R12 ctl1 cleared", d, 32'h0);
      rd(8'h25, d); check("R12 status1", d, 32'h6040);
      rd(8'h00, d); check("R12 holder restored", d, 32'h4000);

      // R2 boot preset
      do_reset(1'b1);
      boot_preset = 1'b0;
      rd(8'h20, d); check("R2 ctl1", d, 32'h0001);
      rd(8'h21, d); check("R2 ctl2", d, 32'h0004);
      wr(8'h10, 32'h005A);
      check("R2 tx works", {23'b0, tx_valid, tx_data}, 32'h15A);

      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule